// File: doc/BRIEF.md
# Debug Serial Command Port

This block is the slave end of a narrow serial link between an external debug controller and a bank of on-chip debug registers. The controller drives a debug clock and a serial data input, both asynchronous to the system clock. The port brings them into the system domain through two-flop synchronizers and finds their edges there. It assembles 8-bit commands, moves 24-bit data words in either direction, and performs single-cycle accesses on a plain register read/write port. The register contents themselves live outside the block.

The serial output serves two purposes. When no data is being read out it rests high. It drops low for two system clock cycles to acknowledge each protocol step:

- entry into debug mode;
- a decoded read, meaning the data is ready;
- a decoded write, meaning the port is ready for the data;
- completion of a write.

During a read it carries the data word, most significant bit first, and advances one bit on every rising edge of the debug clock.

The debug request input has two roles. Raising it takes the port into debug mode. Raising it again later abandons any transfer in progress and returns the command logic to a clean state, which lets the controller recover framing after a glitch. In both cases the controller waits for the acknowledge, then releases the request before it sends a command. Command bits clocked in while the request is still held are discarded.

Top module: `dbg_serial_port`

## Requirements
- R1: During reset, and whenever the port is not in debug mode, the serial output is high and the debug-mode output is low.
- R2: Raising the debug request while out of debug mode sets the debug-mode output and pulls the serial output low for exactly 2 system clock cycles.
- R3: While the debug request stays high after its acknowledge, debug-clock edges cause no acknowledge and shift nothing into the command. The first command after the release is decoded correctly.
- R4: A command is 8 bits, sampled most significant bit first on falling debug-clock edges. Bit 7 = 1 means read and bit 7 = 0 means write. Bits 4:0 give the register address, and bits 6:5 have no effect.
- R5: After a read command the port gives a 2-cycle low acknowledge. Then each of 24 rising debug-clock edges presents the next bit of the addressed register on the serial output, most significant bit first.
- R6: After a write command the port gives a 2-cycle low acknowledge and then takes 24 data bits, most significant bit first, on falling edges. It then asserts the register write strobe for one cycle with that address and data. A second 2-cycle low acknowledge follows directly.
- R7: Raising the debug request during a command or data transfer abandons it and gives a 2-cycle low acknowledge. Once the request is released, the next command is framed from its first bit.
- R8: If the debug request is high when reset is released, the port enters debug mode and gives the entry acknowledge without any debug-clock activity.
- R9: After the falling edge that follows the 24th read bit, the serial output returns high and the port accepts a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_sclk | input | 1 | Debug serial clock from the controller (asynchronous) |
| dbg_sin | input | 1 | Serial command and write data from the controller |
| dbg_req | input | 1 | Debug request; enters debug mode or resynchronizes the port |
| dbg_sout | output | 1 | Serial read data and active-low acknowledge pulses |
| debug_mode | output | 1 | High while the port is in debug mode |
| reg_addr | output | 5 | Debug register address |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 24 | Register write data |
| reg_rdata | input | 24 | Register read data for reg_addr (combinational) |

## Verification
The embedded assertions check these on every cycle:
- the output stays high outside debug mode;
- every acknowledge lasts exactly two cycles;
- a held request keeps the port parked;
- a write strobe is a lone pulse that is always followed by an acknowledge;
- a request during a transfer forces a resync acknowledge.

Some properties span whole serial transactions and only the bench scenarios can show them:
- bit order and edge alignment of both data directions;
- correct address decode with the unused command bits set;
- discarding of bits sent under a held request;
- clean reframing after an aborted command;
- entry into debug mode straight out of reset.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic [2:0] {
    ST_NORM,   // not in debug mode
    ST_ACK,    // serial output held low
    ST_HOLD,   // waiting for request release
    ST_CMD,    // shifting command bits
    ST_DEC,    // decode finished command
    ST_RDOUT,  // presenting read data
    ST_WRIN,   // shifting write data
    ST_WRC     // commit write to register port
  } port_st_t;

endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/dbgp_shift.sv
module dbgp_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (load)       q_n = load_val;
    else if (shift) q_n = {q_r[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q_r <= '0;
    else if (load || shift)  q_r <= q_n;
  end

  assign q = q_r;

  // Load and shift requests come from the controller and must never collide
  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));                                     // R5

  AST_SHIFT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || shift) |=> $stable(q_r));                    // R3

endmodule

// File: rtl/dbgp_ack.sv
module dbgp_ack #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = '0;
    if (active) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign done = active && (cnt_q == LAST);

  AST_ACK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= LAST));                           // R2

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dbgp_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 24,
  parameter int ACK_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_sclk,
  input  logic              dbg_sin,
  input  logic              dbg_req,
  output logic              dbg_sout,
  output logic              debug_mode,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_W);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_sync_n;
  dbgp_sync #(.W(1)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  // Input synchronizers for request, data and serial clock
  logic [2:0] in_raw;
  logic [2:0] in_syn;
  assign in_raw = {dbg_req, dbg_sin, dbg_sclk};
  dbgp_sync #(.W(3)) u_in_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(in_raw), .q(in_syn)
  );

  logic sclk_s, sin_s, req_s, sclk_d;
  assign sclk_s = in_syn[0];
  assign sin_s  = in_syn[1];
  assign req_s  = in_syn[2];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_d <= 1'b0;
    else             sclk_d <= sclk_s;
  end

  logic sclk_rise, sclk_fall;
  assign sclk_rise =  sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s &  sclk_d;

  // Controller state
  port_st_t             st_q, st_n, ret_q, ret_n;
  logic [CNT_W-1:0]     bcnt_q, bcnt_n;
  logic                 out_q, out_n;
  logic                 cmd_shift, dat_load, dat_shift, we_n;
  logic                 ack_low, ack_done;
  logic [CMD_W-1:0]     cmd_q;
  logic [DATA_W-1:0]    dat_q;
  logic                 xfer_busy;

  assign ack_low   = (st_q == ST_ACK);
  assign xfer_busy = (st_q == ST_CMD) || (st_q == ST_RDOUT) || (st_q == ST_WRIN);

  dbgp_shift #(.W(CMD_W)) u_cmd_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(1'b0), .load_val('0),
    .shift(cmd_shift), .sin(sin_s), .q(cmd_q)
  );

  dbgp_shift #(.W(DATA_W)) u_dat_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(dat_load), .load_val(reg_rdata),
    .shift(dat_shift), .sin(sin_s), .q(dat_q)
  );

  dbgp_ack #(.LEN(ACK_LEN)) u_ack (
    .clk(clk), .rst_n(rst_sync_n), .active(ack_low), .done(ack_done)
  );

  // Next-state logic
  always_comb begin
    st_n      = st_q;
    ret_n     = ret_q;
    bcnt_n    = bcnt_q;
    out_n     = out_q;
    cmd_shift = 1'b0;
    dat_load  = 1'b0;
    dat_shift = 1'b0;
    we_n      = 1'b0;
    if (xfer_busy && req_s) begin
      st_n  = ST_ACK;
      ret_n = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_NORM: if (req_s) begin
          st_n  = ST_ACK;
          ret_n = ST_HOLD;
        end
        ST_ACK: if (ack_done) begin
          st_n   = ret_q;
          bcnt_n = '0;
          out_n  = 1'b1;
        end
        ST_HOLD: if (!req_s) begin
          st_n   = ST_CMD;
          bcnt_n = '0;
        end
        ST_CMD: if (sclk_fall) begin
          cmd_shift = 1'b1;
          bcnt_n    = bcnt_q + 1'b1;
          if (bcnt_q == CMD_LAST) st_n = ST_DEC;
        end
        ST_DEC: begin
          st_n = ST_ACK;
          if (cmd_q[CMD_W-1]) begin
            dat_load = 1'b1;
            ret_n    = ST_RDOUT;
          end else begin
            ret_n    = ST_WRIN;
          end
        end
        ST_RDOUT: begin
          if (sclk_rise && (bcnt_q < DATA_END)) begin
            out_n     = dat_q[DATA_W-1];
            dat_shift = 1'b1;
            bcnt_n    = bcnt_q + 1'b1;
          end else if (sclk_fall && (bcnt_q == DATA_END)) begin
            st_n   = ST_CMD;
            bcnt_n = '0;
            out_n  = 1'b1;
          end
        end
        ST_WRIN: if (sclk_fall) begin
          dat_shift = 1'b1;
          bcnt_n    = bcnt_q + 1'b1;
          if (bcnt_q == DATA_LAST) st_n = ST_WRC;
        end
        ST_WRC: begin
          we_n  = 1'b1;
          st_n  = ST_ACK;
          ret_n = ST_CMD;
        end
        default: st_n = ST_NORM;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_NORM;
      ret_q  <= ST_NORM;
      bcnt_q <= '0;
      out_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      ret_q  <= ret_n;
      bcnt_q <= bcnt_n;
      out_q  <= out_n;
    end
  end

  assign reg_we     = (st_q == ST_WRC);
  assign reg_addr   = cmd_q[ADDR_W-1:0];
  assign reg_wdata  = dat_q;
  assign debug_mode = (st_q != ST_NORM);
  assign dbg_sout   = ack_low ? 1'b0 : ((st_q == ST_RDOUT) ? out_q : 1'b1);

  // Command bits between the opcode and the address carry no meaning
  logic unused_rsv;
  assign unused_rsv = ^{cmd_q[CMD_W-2:ADDR_W], we_n};

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !debug_mode |-> dbg_sout);                              // R1

  AST_ACK_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ack_low) |=> ack_low);                            // R2

  AST_ACK_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_low && $past(ack_low)) |=> !ack_low);              // R2

  AST_HOLD_PARKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_HOLD && req_s) |=> (st_q == ST_HOLD));      // R3

  AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_DEC && cmd_q[CMD_W-1]) |=> (ack_low && ret_q == ST_RDOUT)); // R5

  AST_WE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> (!reg_we && ack_low));                       // R6

  AST_RESYNC_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_busy && req_s) |=> (ack_low && ret_q == ST_HOLD)); // R7

endmodule

// File: tb/tb_dbg_serial_port.sv
module tb_dbg_serial_port;

  localparam int HP = 6;  // system clocks per debug-clock half period

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_sclk, dbg_sin, dbg_req;
  logic        dbg_sout, debug_mode;
  logic [4:0]  reg_addr;
  logic        reg_we;
  logic [23:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  dbg_serial_port dut (
    .clk(clk), .rst_n(rst_n), .dbg_sclk(dbg_sclk), .dbg_sin(dbg_sin),
    .dbg_req(dbg_req), .dbg_sout(dbg_sout), .debug_mode(debug_mode),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [23:0] init_val(int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, 8'h3C, b};
  endfunction

  // Register bank behind the port
  logic [23:0] regs [32];
  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= init_val(i);
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
    end
  end

  int n_checks = 0;
  int n_errs   = 0;
  int low_cycles = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!dbg_sout) low_cycles++;

  // Scoreboard queues
  logic [28:0] wr_q [$];   // {addr, data}
  logic [23:0] rd_q [$];

  // Write monitor
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wr_q.size() == 0) begin
        check(1'b0, "R6", "unexpected write strobe", {3'b0, reg_addr, reg_wdata}, 32'h0);
      end else begin
        logic [28:0] e;
        e = wr_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R6", "write addr/data",
              {3'b0, reg_addr, reg_wdata}, {3'b0, e});
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      dbg_sin  = v[i];
      dbg_sclk = 1'b1;
      tick(HP);
      dbg_sclk = 1'b0;
      if (i > 0) tick(HP);
    end
  endtask

  task automatic wait_ack(string req);
    int t = 0;
    int n = 0;
    while (dbg_sout !== 1'b0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (t >= 300) begin
      check(1'b0, req, "acknowledge timeout", 32'(t), 32'd300);
    end else begin
      while (dbg_sout === 1'b0 && n < 10) begin
        n++;
        @(negedge clk);
      end
      check(n == 2, req, "acknowledge length", 32'(n), 32'd2);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [23:0] d);
    wr_q.push_back({a, d});
    send_bits({24'b0, 3'b000, a}, 8);
    wait_ack("R6");
    send_bits({8'b0, d}, 24);
    wait_ack("R6");
    tick(4);
    check(wr_q.size() == 0, "R6", "write pending", 32'(wr_q.size()), 32'd0);
  endtask

  task automatic do_read(logic [7:0] cmd, logic [23:0] exp, string req);
    logic [23:0] got;
    logic [23:0] e;
    rd_q.push_back(exp);
    send_bits({24'b0, cmd}, 8);
    wait_ack("R5");
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk);
      dbg_sclk = 1'b1;
      tick(HP);
      got[i] = dbg_sout;
      dbg_sclk = 1'b0;
      if (i > 0) tick(HP);
    end
    e = rd_q.pop_front();
    check(got == e, req, "read word", {8'b0, got}, {8'b0, e});
    tick(8);
    check(dbg_sout == 1'b1, "R9", "output high after read", {31'b0, dbg_sout}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; dbg_sclk = 1'b0; dbg_sin = 1'b0; dbg_req = 1'b0;
    tick(5);
    check(dbg_sout == 1'b1, "R1", "output during reset", {31'b0, dbg_sout}, 32'd1);
    rst_n = 1'b1;
    tick(20);
    check(dbg_sout == 1'b1 && low_cycles == 0, "R1", "idle output high", 32'(low_cycles), 32'd0);
    check(debug_mode == 1'b0, "R1", "debug mode idle", {31'b0, debug_mode}, 32'd0);

    // R2: enter debug mode
    dbg_req = 1'b1;
    wait_ack("R2");
    check(debug_mode == 1'b1, "R2", "debug mode entered", {31'b0, debug_mode}, 32'd1);

    // R3: bits sent under a held request are discarded
    base = low_cycles;
    send_bits(32'hA7, 8);
    tick(20);
    check(low_cycles == base, "R3", "no ack while held", 32'(low_cycles), 32'(base));
    dbg_req = 1'b0;
    tick(10);
    do_read(8'h86, init_val(6), "R3");

    // R6 / R5 / R4: write then read back
    do_write(5'd3, 24'hA5C30F);
    do_read(8'h83, 24'hA5C30F, "R5");
    do_read(8'hFF, init_val(31), "R4");
    do_write(5'd16, 24'hFFFFFF);
    do_write(5'd17, 24'h000001);
    do_read(8'hF0, 24'hFFFFFF, "R4");
    do_read(8'h91, 24'h000001, "R5");

    // R7: abort mid-command and reframe
    send_bits(32'h8, 4);
    tick(HP);
    dbg_req = 1'b1;
    wait_ack("R7");
    check(debug_mode == 1'b1, "R7", "debug mode kept", {31'b0, debug_mode}, 32'd1);
    dbg_req = 1'b0;
    tick(10);
    do_read(8'h85, init_val(5), "R7");

    // R7: abort during write data
    send_bits(32'h04, 8);
    wait_ack("R6");
    send_bits(32'h5, 10);
    tick(HP);
    dbg_req = 1'b1;
    wait_ack("R7");
    dbg_req = 1'b0;
    tick(10);
    do_read(8'h84, init_val(4), "R7");

    // R8: request held across reset release
    rst_n = 1'b0;
    dbg_req = 1'b1;
    tick(5);
    check(dbg_sout == 1'b1 && debug_mode == 1'b0, "R1", "reset forces idle",
          {30'b0, dbg_sout, debug_mode}, 32'd2);
    rst_n = 1'b1;
    wait_ack("R8");
    check(debug_mode == 1'b1, "R8", "debug mode out of reset", {31'b0, debug_mode}, 32'd1);
    dbg_req = 1'b0;
    tick(10);
    do_read(8'h82, init_val(2), "R8");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule